// File: doc/BRIEF.md
# Colour Lookup Table Loader

This block runs once after reset and sets up an external video DAC before any pixel is shown. In indexed mode it fills the DAC's 256-entry colour lookup table. Each entry is a table address followed by a red, a green and a blue byte. An internal formula produces the bytes, so nothing has to be stored. The block then writes the DAC control register to select indexed colour. After that, a pixel value on the display path is simply the table address of the colour it wants.

In direct mode the DAC is set up for 15-bit direct colour instead. A single control-register write takes the place of the whole table load. The mode input is captured once, in the first clock after reset.

The DAC programming lines are shared with another device. An active-low output-disable line to that device is held low from reset until the load is complete. All writes use a byte-wide bus with a select field, a one-clock strobe and a ready input. A done flag marks the end of the sequence. The output-disable line is released one clock after done rises.

Top module: `clut_loader`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busStrobe, done, indexedMode and shareOeN are all low.
- R2: In indexed mode the table is written as 256 entries with indices 0 to 255 in ascending order. Each entry is four writes: first busSel=0 with busData equal to the index, then three writes with busSel=1 carrying red, green and blue in that order.
- R3: The colour bytes for entry i are red = i, green = 255 - i, and blue = i with its two 4-bit halves swapped.
- R4: In indexed mode the last table write is followed by one control write (busSel=2, busData=8'h00). In direct mode the complete sequence is a single control write (busSel=2, busData=8'h01).
- R5: busStrobe is high for exactly one clock per write and is never high in two consecutive cycles.
- R6: busStrobe is high only in the cycle after one in which busReady was high. While busReady stays low, no write occurs.
- R7: modeDirect is sampled in the first clock after reset (1 = direct, 0 = indexed). Later changes to it have no effect until the next reset.
- R8: done rises in the cycle after the final strobe and stays high until reset. indexedMode is high together with done only when indexed mode was sampled.
- R9: shareOeN stays low through every write and goes high exactly one cycle after done rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeDirect | input | 1 | 1 selects 15-bit direct colour, 0 selects indexed colour |
| busReady | input | 1 | DAC can accept the next write |
| busStrobe | output | 1 | One-clock write strobe |
| busSel | output | 2 | Write target: 0 address, 1 palette data, 2 control |
| busData | output | 8 | Write data byte |
| done | output | 1 | Setup sequence complete |
| indexedMode | output | 1 | Display path uses table indices as pixel values |
| shareOeN | output | 1 | Output disable to the device sharing the bus, active low |

## Verification
Some rules are checked on every cycle by assertions: the strobe is one clock wide, every strobe is preceded by ready, done never drops once set, and the shared-bus disable is held low before done and released right after it. The bench's scenarios are needed for the content and order of the 1025 writes, the colour formula, the control value for each mode, and the way the mode input is ignored after sampling. The same goes for the exact cycles of done and the disable release under fast, alternating and sparse ready patterns.

// File: rtl/clut_pkg.sv
package clut_pkg;

  // Write target codes carried on busSel
  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  // Strobes from the controller to the datapath, valid for one cycle
  typedef struct packed {
    logic fire;        // launch a write on the next edge
    logic selAddr;     // write the entry index to the address register
    logic selRed;      // write the red byte of the current entry
    logic selGrn;      // write the green byte
    logic selBlu;      // write the blue byte
    logic selCtrl;     // write the DAC control register
    logic ctrlDirect;  // control value selects direct colour
    logic nextIndex;   // advance the entry index
    logic clrIndex;    // restart the entry index at zero
  } ctrlCmd_t;

endpackage

// File: rtl/clut_datapath.sv
module clut_datapath
  import clut_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] CTRL_INDEXED = 8'h00,
  parameter logic [DATA_W-1:0] CTRL_DIRECT = 8'h01
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlCmd_t          cmd,
  output logic              lastEntry,
  output logic              busStrobe,
  output logic [1:0]        busSel,
  output logic [DATA_W-1:0] busData
);

  localparam int IDXW = $clog2(ENTRIES);
  localparam int HALF = DATA_W / 2;
  localparam int NCHAN = 3;

  logic [IDXW-1:0]   idx;
  logic [DATA_W-1:0] idxByte;
  logic [DATA_W-1:0] chan [NCHAN];
  logic [DATA_W-1:0] nextData;
  logic [1:0]        nextSel;

  // Entry index: cleared at start, advanced after each blue byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx <= '0;
    end else if (cmd.clrIndex) begin
      idx <= '0;
    end else if (cmd.nextIndex) begin
      idx <= idx + 1'b1;
    end
  end

  assign lastEntry = (idx == IDXW'(ENTRIES - 1));
  assign idxByte = DATA_W'(idx);

  // Colour formula, one generator per channel
  for (genvar c = 0; c < NCHAN; c++) begin : g_chan
    if (c == 0) begin : g_red
      assign chan[c] = idxByte;
    end else if (c == 1) begin : g_grn
      assign chan[c] = ~idxByte;
    end else begin : g_blu
      assign chan[c] = {idxByte[HALF-1:0], idxByte[DATA_W-1:HALF]};
    end
  end

  always_comb begin
    nextData = '0;
    nextSel = SEL_ADDR;
    if (cmd.selAddr) begin
      nextData = idxByte;
      nextSel = SEL_ADDR;
    end else if (cmd.selRed) begin
      nextData = chan[0];
      nextSel = SEL_DATA;
    end else if (cmd.selGrn) begin
      nextData = chan[1];
      nextSel = SEL_DATA;
    end else if (cmd.selBlu) begin
      nextData = chan[2];
      nextSel = SEL_DATA;
    end else if (cmd.selCtrl) begin
      nextData = cmd.ctrlDirect ? CTRL_DIRECT : CTRL_INDEXED;
      nextSel = SEL_CTRL;
    end
  end

  // Registered bus outputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busStrobe <= 1'b0;
      busSel <= SEL_ADDR;
      busData <= '0;
    end else begin
      busStrobe <= cmd.fire;
      if (cmd.fire) begin
        busSel <= nextSel;
        busData <= nextData;
      end
    end
  end

  // R5: strobe lasts one clock
  a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    busStrobe |=> !busStrobe);

  // R2: the index never wraps before the sequence moves to the control write
  a_r2_index_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.nextIndex && lastEntry) |=> !cmd.selAddr);

endmodule

// File: rtl/clut_ctrl.sv
module clut_ctrl
  import clut_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     modeDirect,
  input  logic     busReady,
  input  logic     lastEntry,
  output ctrlCmd_t cmd,
  output logic     done,
  output logic     indexedMode,
  output logic     shareOeN
);

  typedef enum logic [2:0] {
    S_START, S_ADDR, S_RED, S_GRN, S_BLU, S_CTRL, S_SETTLE, S_DONE
  } state_e;

  state_e state, nextState;
  logic   holdOff;   // high in the cycle the strobe is out
  logic   modeReg;
  logic   canIssue;

  assign canIssue = busReady && !holdOff;

  always_comb begin
    cmd = '0;
    nextState = state;
    unique case (state)
      S_START: begin
        cmd.clrIndex = 1'b1;
        nextState = modeDirect ? S_CTRL : S_ADDR;
      end
      S_ADDR: if (canIssue) begin
        cmd.fire = 1'b1;
        cmd.selAddr = 1'b1;
        nextState = S_RED;
      end
      S_RED: if (canIssue) begin
        cmd.fire = 1'b1;
        cmd.selRed = 1'b1;
        nextState = S_GRN;
      end
      S_GRN: if (canIssue) begin
        cmd.fire = 1'b1;
        cmd.selGrn = 1'b1;
        nextState = S_BLU;
      end
      S_BLU: if (canIssue) begin
        cmd.fire = 1'b1;
        cmd.selBlu = 1'b1;
        cmd.nextIndex = 1'b1;
        nextState = lastEntry ? S_CTRL : S_ADDR;
      end
      S_CTRL: if (canIssue) begin
        cmd.fire = 1'b1;
        cmd.selCtrl = 1'b1;
        cmd.ctrlDirect = modeReg;
        nextState = S_SETTLE;
      end
      S_SETTLE: nextState = S_DONE;
      S_DONE: nextState = S_DONE;
      default: nextState = S_START;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_START;
      holdOff <= 1'b0;
      modeReg <= 1'b0;
      shareOeN <= 1'b0;
    end else begin
      state <= nextState;
      holdOff <= cmd.fire;
      if (state == S_START) begin
        modeReg <= modeDirect;
      end
      shareOeN <= (state == S_DONE);
    end
  end

  assign done = (state == S_DONE);
  assign indexedMode = done && !modeReg;

  // R8: done is sticky
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done);

  // R9: shared bus stays disabled until done
  a_r9_oe_low_before_done: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> !shareOeN);

  // R9: release one cycle after done
  a_r9_oe_release: assert property (@(posedge clk) disable iff (!rstN)
    done |=> shareOeN);

  // R7: the sampled mode holds after the start cycle
  a_r7_mode_held: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_START) |=> $stable(modeReg));

endmodule

// File: rtl/clut_loader.sv
module clut_loader
  import clut_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] CTRL_INDEXED = 8'h00,
  parameter logic [DATA_W-1:0] CTRL_DIRECT = 8'h01
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeDirect,
  input  logic              busReady,
  output logic              busStrobe,
  output logic [1:0]        busSel,
  output logic [DATA_W-1:0] busData,
  output logic              done,
  output logic              indexedMode,
  output logic              shareOeN
);

  ctrlCmd_t cmd;
  logic     lastEntry;

  clut_ctrl u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .modeDirect(modeDirect),
    .busReady(busReady),
    .lastEntry(lastEntry),
    .cmd(cmd),
    .done(done),
    .indexedMode(indexedMode),
    .shareOeN(shareOeN)
  );

  clut_datapath #(
    .ENTRIES(ENTRIES),
    .DATA_W(DATA_W),
    .CTRL_INDEXED(CTRL_INDEXED),
    .CTRL_DIRECT(CTRL_DIRECT)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .cmd(cmd),
    .lastEntry(lastEntry),
    .busStrobe(busStrobe),
    .busSel(busSel),
    .busData(busData)
  );

  // R6: a strobe follows a cycle with ready high
  a_r6_ready_first: assert property (@(posedge clk) disable iff (!rstN)
    busStrobe |-> $past(busReady));

  // R9: no write while the other device may drive the lines
  a_r9_no_write_released: assert property (@(posedge clk) disable iff (!rstN)
    busStrobe |-> !shareOeN);

endmodule

// File: tb/clut_loader_tb.sv
module clut_loader_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeDirect = 1'b0;
  logic       busReady = 1'b0;
  logic       busStrobe;
  logic [1:0] busSel;
  logic [7:0] busData;
  logic       done;
  logic       indexedMode;
  logic       shareOeN;

  clut_loader u_dut (
    .clk(clk), .rstN(rstN), .modeDirect(modeDirect), .busReady(busReady),
    .busStrobe(busStrobe), .busSel(busSel), .busData(busData),
    .done(done), .indexedMode(indexedMode), .shareOeN(shareOeN)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Scenario table: mode, ready pattern, mode toggle, expected write count
  localparam int NSC = 5;
  localparam int SC_MODE   [NSC] = '{0, 1, 0, 1, 0};
  localparam int SC_READY  [NSC] = '{0, 0, 1, 2, 2};
  localparam int SC_TOGGLE [NSC] = '{0, 0, 1, 1, 0};
  localparam int SC_EXPN   [NSC] = '{1025, 1, 1025, 1, 1025};

  // Monitor state
  int         readyPat = 3;
  int         toggleAt = -1;
  int         nWrites = 0;
  logic [1:0] logSel [0:1099];
  logic [7:0] logData [0:1099];
  int         lastStrobeCyc = -1;
  int         doneRiseCyc = -1;
  int         oeRiseCyc = -1;
  int         errDouble = 0;
  int         errNoReady = 0;
  int         errOeHigh = 0;
  logic       prevStrobe = 1'b0;
  logic       prevDone = 1'b0;
  logic       prevOe = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (busStrobe) begin
        if (nWrites < 1100) begin
          logSel[nWrites] = busSel;
          logData[nWrites] = busData;
        end
        nWrites++;
        lastStrobeCyc = cyc;
        if (prevStrobe) errDouble++;
        if (!busReady) errNoReady++;
        if (shareOeN) errOeHigh++;
      end
      if (done && !prevDone) doneRiseCyc = cyc;
      if (shareOeN && !prevOe) oeRiseCyc = cyc;
      if (toggleAt >= 0 && cyc == toggleAt) modeDirect = ~modeDirect;
    end
    prevStrobe = busStrobe;
    prevDone = done;
    prevOe = shareOeN;
    case (readyPat)
      0: busReady = 1'b1;
      1: busReady = cyc[0];
      2: busReady = (cyc % 4 == 0);
      default: busReady = 1'b0;
    endcase
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [9:0] expWrite(input int k, input bit direct);
    logic [7:0] e;
    if (direct) return {2'd2, 8'h01};
    if (k == 1024) return {2'd2, 8'h00};
    e = 8'(k / 4);
    case (k % 4)
      0: return {2'd0, e};
      1: return {2'd1, e};
      2: return {2'd1, 8'(255 - k / 4)};
      default: return {2'd1, e[3:0], e[7:4]};
    endcase
  endfunction

  task automatic startRun(input bit mode, input int pat, input bit toggle);
    @(negedge clk);
    rstN = 1'b0;
    readyPat = pat;
    modeDirect = mode;
    toggleAt = -1;
    nWrites = 0;
    lastStrobeCyc = -1;
    doneRiseCyc = -1;
    oeRiseCyc = -1;
    errDouble = 0;
    errNoReady = 0;
    errOeHigh = 0;
    repeat (3) @(negedge clk);
    if (toggle) toggleAt = cyc + 1;
    rstN = 1'b1;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!busStrobe && !done && !indexedMode && !shareOeN, "R1 in reset",
          {busStrobe, done, indexedMode, shareOeN}, 0);

    // Table-driven scenarios
    for (int s = 0; s < NSC; s++) begin
      int mism;
      int firstBad;
      logic [9:0] ev;
      bit direct;
      direct = SC_MODE[s][0];
      startRun(direct, SC_READY[s], SC_TOGGLE[s][0]);
      @(negedge clk);
      // R1: first cycle after reset
      check(!busStrobe && !done && !shareOeN, "R1 after release",
            {busStrobe, done, shareOeN}, 0);
      waitDone();
      // R2 R4 R7: write count follows the sampled mode
      check(nWrites == SC_EXPN[s], "R2/R4/R7 write count", nWrites, SC_EXPN[s]);
      mism = 0;
      firstBad = -1;
      for (int k = 0; k < nWrites && k < 1100; k++) begin
        ev = expWrite(k, direct);
        if ({logSel[k], logData[k]} != ev) begin
          if (firstBad < 0) firstBad = k;
          mism++;
        end
      end
      if (firstBad >= 0) begin
        ev = expWrite(firstBad, direct);
        check(0, "R2/R3/R4 write content", {logSel[firstBad], logData[firstBad]}, ev);
      end else begin
        check(1, "R2/R3/R4 write content", 0, 0);
      end
      check(errDouble == 0, "R5 strobe width", errDouble, 0);
      check(errNoReady == 0, "R6 ready before strobe", errNoReady, 0);
      check(errOeHigh == 0, "R9 write while released", errOeHigh, 0);
      check(doneRiseCyc == lastStrobeCyc + 1, "R8 done timing", doneRiseCyc, lastStrobeCyc + 1);
      check(oeRiseCyc == doneRiseCyc + 1, "R9 release timing", oeRiseCyc, doneRiseCyc + 1);
      check(indexedMode == !direct, "R8 indexedMode", indexedMode, !direct);
    end

    // R6: ready held low stalls the sequence
    startRun(1'b0, 3, 1'b0);
    repeat (50) @(negedge clk);
    check(nWrites == 0 && !done && !shareOeN, "R6 stalled without ready",
          nWrites, 0);
    readyPat = 0;
    waitDone();
    check(nWrites == 1025, "R6 resumes on ready", nWrites, 1025);

    // R8: done stays, no further writes
    repeat (20) @(negedge clk);
    check(done && shareOeN && nWrites == 1025, "R8 done sticky", {done, shareOeN}, 3);

    // R1: reset mid-load
    startRun(1'b0, 0, 1'b0);
    repeat (30) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(!busStrobe && !done && !indexedMode && !shareOeN, "R1 mid-load reset",
          {busStrobe, done, indexedMode, shareOeN}, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule